// File: doc/BRIEF.md
# Connector Presence Interrupt

This block watches one 5 V presence line per connector port. Each line is asynchronous to the control clock, so it is brought into the clock domain through a chain of flops. The block then shows the current connect state of every port. A single shared interrupt flag is set whenever any port is plugged or unplugged. The flag drives the interrupt pin and stays set until the host reads the status byte, which the register logic signals with a one-cycle read strobe.

The same block gates the high-speed path enable. An active-low external enable pin is combined with an enable bit from the control register. From that result, the port selection and the main-power indication, the block derives one pull-down enable per port.

Top module: `conn_presence_irq`

## Requirements
- R1: After reset `conn_state` is all zero. Bit i of `conn_state` follows bit i of `pwr5v_in`, 1 meaning present, and shows a change after the second rising clock edge following that change.
- R2: A low-to-high change on any presence input sets `irq_out` after the third rising clock edge following the input change.
- R3: A high-to-low change on any presence input sets `irq_out` with the same latency as R2.
- R4: Once set, `irq_out` stays high until `rd_status` is high at a rising edge. It is low after that edge when no presence change is registered at the same edge.
- R5: When a presence change and `rd_status` land on the same rising edge, `irq_out` is high after that edge, so the event is kept.
- R6: Synchronous reset (`rst_n` low at a rising edge) drives `irq_out` low. A read strobe while the flag is clear and no change is pending leaves `irq_out` low.
- R7: `path_en` is 1 only when `oe_n` is 0 and `reg_path_en` is 1. It is 0 for the other three combinations.
- R8: `pulldown_en[i]` is 0 only when `path_en` is 1, `main_pwr_ok` is 1 and `port_sel` equals i (value k selects port k). In every other case it is 1.
- R9: Simultaneous changes on several ports register as one event. `conn_state` shows every changed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr5v_in | input | NUM_PORTS | Asynchronous 5 V presence per port |
| rd_status | input | 1 | One-cycle strobe: host read the status byte |
| oe_n | input | 1 | External path enable pin, active low |
| reg_path_en | input | 1 | Register path enable bit, active high |
| main_pwr_ok | input | 1 | Main supply present |
| port_sel | input | SEL_W | Selected port number |
| conn_state | output | NUM_PORTS | Synchronised connect state per port |
| irq_out | output | 1 | Sticky plug/unplug interrupt flag |
| path_en | output | 1 | High-speed path enable |
| pulldown_en | output | NUM_PORTS | Per-port channel pull-down enable |

## Verification
The bench builds the block with its defaults: four ports and a two-stage synchroniser. These values let every port number be selected and give a fixed three-edge latency from input to flag, which the directed checks sample exactly. With four ports, all three cases can be reached in one run: two ports changing together, a change landing on the same edge as the read strobe, and each selected port under all eight combinations of pin, bit and main power.

// File: rtl/conn_presence_pkg.sv
// Package: shared defaults for the connector presence interrupt block.
// Assumes: consumers derive their own widths from these values.
package conn_presence_pkg;
    localparam int unsigned DEF_PORTS       = 4;
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/conn_presence_sync.sv
// Module: multi-bit flop-chain synchroniser for presence inputs.
// Assumes: each bit is an independent level; bits are not coherent as a word.
module conn_presence_sync #(
    parameter int unsigned WIDTH  = conn_presence_pkg::DEF_PORTS,
    parameter int unsigned STAGES = conn_presence_pkg::DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // First stage samples the asynchronous lines.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/conn_presence_event.sv
// Module: edge detection on synchronised presence bits and sticky flag.
// Assumes: inputs are synchronous; a set event outranks the read clear.
module conn_presence_event #(
    parameter int unsigned WIDTH = conn_presence_pkg::DEF_PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic             clr_req,
    output logic             flag
);
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] toggled;
    logic             any_event;

    // Keep last cycle's levels for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level;
    end

    always_comb begin
        toggled   = level ^ level_q;
        any_event = |toggled;
    end

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (any_event) flag <= 1'b1;
        else if (clr_req)   flag <= 1'b0;
    end
endmodule

// File: rtl/conn_presence_gate.sv
// Module: path enable gating and per-port pull-down control.
// Assumes: combinational; port_sel value k addresses port k.
module conn_presence_gate #(
    parameter int unsigned NUM_PORTS = conn_presence_pkg::DEF_PORTS,
    parameter int unsigned SEL_W     = $clog2(NUM_PORTS)
) (
    input  logic                 oe_n,
    input  logic                 reg_path_en,
    input  logic                 main_pwr_ok,
    input  logic [SEL_W-1:0]     port_sel,
    output logic                 path_en,
    output logic [NUM_PORTS-1:0] pulldown_en
);
    logic drive_ok;

    // Path is live only with the pin asserted and the bit set.
    always_comb begin
        path_en  = ~oe_n & reg_path_en;
        drive_ok = path_en & main_pwr_ok;
    end

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_pd
            // Pull down every port that is not actively driven.
            assign pulldown_en[p] = ~(drive_ok & (port_sel == SEL_W'(p)));
        end
    endgenerate
endmodule

// File: rtl/conn_presence_irq.sv
// Module: top of the connector presence interrupt block.
// Assumes: rd_status is a single-cycle strobe from the register interface.
module conn_presence_irq #(
    parameter int unsigned NUM_PORTS   = conn_presence_pkg::DEF_PORTS,
    parameter int unsigned SYNC_STAGES = conn_presence_pkg::DEF_SYNC_STAGES,
    localparam int unsigned SEL_W      = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] pwr5v_in,
    input  logic                 rd_status,
    input  logic                 oe_n,
    input  logic                 reg_path_en,
    input  logic                 main_pwr_ok,
    input  logic [SEL_W-1:0]     port_sel,
    output logic [NUM_PORTS-1:0] conn_state,
    output logic                 irq_out,
    output logic                 path_en,
    output logic [NUM_PORTS-1:0] pulldown_en
);
    conn_presence_sync #(.WIDTH(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwr5v_in),
        .sync_out (conn_state)
    );

    conn_presence_event #(.WIDTH(NUM_PORTS)) u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (conn_state),
        .clr_req (rd_status),
        .flag    (irq_out)
    );

    conn_presence_gate #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_gate (
        .oe_n        (oe_n),
        .reg_path_en (reg_path_en),
        .main_pwr_ok (main_pwr_ok),
        .port_sel    (port_sel),
        .path_en     (path_en),
        .pulldown_en (pulldown_en)
    );
endmodule

// File: rtl/conn_presence_irq_chk.sv
// Module: assertion checker bound to conn_presence_irq.
// Assumes: observes only the top-level ports.
module conn_presence_irq_chk #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned SEL_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_status,
    input logic                 oe_n,
    input logic                 reg_path_en,
    input logic                 main_pwr_ok,
    input logic [SEL_W-1:0]     port_sel,
    input logic [NUM_PORTS-1:0] conn_state,
    input logic                 irq_out,
    input logic                 path_en,
    input logic [NUM_PORTS-1:0] pulldown_en
);
    // R2 R3 R5: any change of connect state leads to a set flag.
    assert_set_on_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_state != $past(conn_state)) |=> irq_out);

    // R4: read with no change clears the flag.
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && conn_state == $past(conn_state)) |=> !irq_out);

    // R4: without read or change the flag holds.
    assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_status && conn_state == $past(conn_state)) |=> $stable(irq_out));

    // R7: enable needs the pin low and the bit high.
    assert_path_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        path_en |-> (!oe_n && reg_path_en));

    // R8: at most one port released from pull-down.
    assert_pd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pulldown_en));

    // R8: disabled path or missing power pulls every port down.
    assert_pd_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_en || !main_pwr_ok) |-> (&pulldown_en));

    // R8: active path releases the selected port.
    assert_pd_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (path_en && main_pwr_ok) |-> !pulldown_en[port_sel]);
endmodule

bind conn_presence_irq conn_presence_irq_chk #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_status   (rd_status),
    .oe_n        (oe_n),
    .reg_path_en (reg_path_en),
    .main_pwr_ok (main_pwr_ok),
    .port_sel    (port_sel),
    .conn_state  (conn_state),
    .irq_out     (irq_out),
    .path_en     (path_en),
    .pulldown_en (pulldown_en)
);

// File: tb/conn_presence_irq_tb.sv
module conn_presence_irq_tb;
    localparam int NP = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pwr5v_in = '0;
    logic          rd_status = 1'b0;
    logic          oe_n = 1'b1;
    logic          reg_path_en = 1'b0;
    logic          main_pwr_ok = 1'b0;
    logic [SW-1:0] port_sel = '0;
    logic [NP-1:0] conn_state;
    logic          irq_out;
    logic          path_en;
    logic [NP-1:0] pulldown_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    conn_presence_irq u_dut (
        .clk(clk), .rst_n(rst_n), .pwr5v_in(pwr5v_in), .rd_status(rd_status),
        .oe_n(oe_n), .reg_path_en(reg_path_en), .main_pwr_ok(main_pwr_ok),
        .port_sel(port_sel), .conn_state(conn_state), .irq_out(irq_out),
        .path_en(path_en), .pulldown_en(pulldown_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_strobe();
        rd_status = 1'b1;
        step(1);
        rd_status = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pwr5v_in = '0;
        step(3);
        chk(conn_state == 0, "R1 reset conn", conn_state, 0);
        chk(irq_out == 0, "R6 reset irq", irq_out, 0);
        rst_n = 1'b1;
        step(2);
        chk(irq_out == 0, "R6 idle irq", irq_out, 0);
    endtask

    task automatic t_plug();
        pwr5v_in = 4'b0100;
        step(1);
        chk(conn_state == 0, "R1 one-edge latency", conn_state, 0);
        step(1);
        chk(conn_state == 4'b0100, "R1 conn after sync", conn_state, 4'b0100);
        chk(irq_out == 0, "R2 irq not yet", irq_out, 0);
        step(1);
        chk(irq_out == 1, "R2 irq on plug", irq_out, 1);
        step(4);
        chk(irq_out == 1, "R4 irq sticky", irq_out, 1);
        read_strobe();
        chk(irq_out == 0, "R4 read clears", irq_out, 0);
    endtask

    task automatic t_unplug();
        pwr5v_in = 4'b0000;
        step(2);
        chk(conn_state == 0, "R1 conn after unplug", conn_state, 0);
        step(1);
        chk(irq_out == 1, "R3 irq on unplug", irq_out, 1);
        read_strobe();
        chk(irq_out == 0, "R4 cleared after unplug", irq_out, 0);
    endtask

    task automatic t_idle_read();
        read_strobe();
        step(1);
        chk(irq_out == 0, "R6 read with no flag", irq_out, 0);
    endtask

    task automatic t_set_wins();
        pwr5v_in = 4'b0001;
        step(2);
        rd_status = 1'b1;
        step(1);
        rd_status = 1'b0;
        chk(irq_out == 1, "R5 set beats clear", irq_out, 1);
        step(2);
        chk(irq_out == 1, "R5 flag kept", irq_out, 1);
        read_strobe();
        chk(irq_out == 0, "R4 clear after R5", irq_out, 0);
    endtask

    task automatic t_multi();
        pwr5v_in = 4'b1010;
        step(3);
        chk(conn_state == 4'b1010, "R9 conn multi", conn_state, 4'b1010);
        chk(irq_out == 1, "R9 irq multi", irq_out, 1);
        read_strobe();
        step(2);
        chk(irq_out == 0, "R9 single event", irq_out, 0);
        pwr5v_in = 4'b0110;
        step(3);
        chk(conn_state == 4'b0110, "R9 conn swap", conn_state, 4'b0110);
        chk(irq_out == 1, "R9 irq swap", irq_out, 1);
        read_strobe();
    endtask

    task automatic t_gate();
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < NP; s++) begin
                logic ep;
                logic [NP-1:0] epd;
                oe_n = c[0]; reg_path_en = c[1]; main_pwr_ok = c[2];
                port_sel = SW'(s);
                #1;
                ep  = !c[0] && c[1];
                epd = '1;
                if (ep && c[2]) epd[s] = 1'b0;
                chk(path_en == ep, "R7 path enable", path_en, ep);
                chk(pulldown_en == epd, "R8 pulldown", pulldown_en, epd);
            end
        end
        step(1);
    endtask

    initial begin
        step(1);
        t_reset();
        t_plug();
        t_unplug();
        t_idle_read();
        t_set_wins();
        t_multi();
        t_gate();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule